// File: doc/BRIEF.md
# SerDes Mode and Direction Controller

This block turns the static configuration pins of a bidirectional 12-bit serializer/deserializer into the internal enables that the datapath, the PLL and the pad drivers need. Two range-select pins choose between power-down and three reference frequency ranges. A direction pin chooses serializer or deserializer operation. A multiplier pin chooses plain or overclocked framing. The block also owns the parallel output register. That register holds the last deserialized word across a turn-around.

The reference clock is sampled as data on a free-running system clock through a two-flop synchronizer. After power-up the block assumes an externally supplied bit clock. The first reference transition latches the block into reference-clock serialization for good, and only power-down clears that latch. A loss-of-clock counter drops the PLL and serial I/O enables when the reference goes quiet but leaves the internal references on, and the next transition brings them back. Each time the PLL is enabled, a lock-wait counter must expire before the ready output permits data capture.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: With both range pins low (power-down), `pd_rst` is high and `refs_en`, `pll_en`, `serial_io_en`, `par_oe`, `ser_en`, `des_en`, `frame_ovr` and `ready` are low. From the next clock on, `ref_mode` is 0 and `par_dout` is 0.
- R2: `range_code` equals {S2 pin, S1 pin} (`rng_b` as bit 1, `rng_a` as bit 0) when not powered down, and is 0 in power-down.
- R3: `dir_out` is always the inverse of `dir_in`. Outside power-down, `ser_en` equals `dir_in` and `des_en` equals its inverse.
- R4: `par_oe` is high only when `dir_in` is low and the block is not powered down.
- R5: `par_dout` loads `des_word` on a clock where `des_en` and `des_vld` are both high. Otherwise it keeps its value, including across a change to serializer direction.
- R6: Outside power-down, `frame_ovr` is 1 when `mult_sel` is 0 (overclocked, 7-1/3x) and 0 when `mult_sel` is 1 (standard, 7x).
- R7: A transition of `ref_clk` that has passed the two-flop synchronizer sets `ref_mode` and `pll_en` on the third rising clock edge after the change. `ref_mode` then stays set until power-down. A level held on `ref_clk` since power-up is not a transition.
- R8: After `LOSS_TIMEOUT` clock cycles with no detected transition, `pll_en` and `serial_io_en` drop while `refs_en` and `ref_mode` stay high. The next detected transition raises them again.
- R9: In reference-clock mode, `ready` rises only after `pll_en` has been high for `LOCK_WAIT` consecutive clocks, and it falls at once when `pll_en` falls.
- R10: Before any reference transition after power-up (external bit clock), `serial_io_en` and `ready` are high and `pll_en` is low. The first transition drops `ready` until the lock wait completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rng_a | input | 1 | Range select, low bit |
| rng_b | input | 1 | Range select, high bit |
| dir_in | input | 1 | 1 = serializer, 0 = deserializer |
| mult_sel | input | 1 | 1 = 7x standard, 0 = 7-1/3x overclocked |
| ref_clk | input | 1 | Reference clock, sampled as data |
| des_word | input | DW | Word from the deserializer datapath |
| des_vld | input | 1 | Word boundary found, `des_word` valid |
| dir_out | output | 1 | Inverted direction for the partner device |
| par_oe | output | 1 | Parallel port driver enable |
| par_dout | output | DW | Held parallel output word |
| range_code | output | 2 | Selected frequency range, 0 in power-down |
| ser_en | output | 1 | Serializer datapath enable |
| des_en | output | 1 | Deserializer datapath enable |
| pd_rst | output | 1 | Power-down reset to the rest of the device |
| refs_en | output | 1 | Internal references enabled |
| pll_en | output | 1 | PLL enable |
| serial_io_en | output | 1 | Differential serial I/O enable |
| ref_mode | output | 1 | Sticky: reference-clock serialization selected |
| frame_ovr | output | 1 | Overclocked framing selected |
| ready | output | 1 | Clock source stable, data capture permitted |

## Verification
The hardest state to reach is a loss of reference clock after the sticky latch has been set. There, the PLL and serial I/O must drop while the references and the latch stay on, and a single new edge must restart the lock wait. The stimulus gets there by toggling the reference until ready rises, holding it still for longer than the timeout, and then toggling it again. A later power-down with the reference held high must show that the latch clears and that a static level does not re-arm it. A cycle-accurate model in the bench, built on a queue of sampled reference values, follows every one of these steps.

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl #(
  parameter int DW           = 12,
  parameter int LOSS_TIMEOUT = 256,
  parameter int LOCK_WAIT    = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rng_a,
  input  logic          rng_b,
  input  logic          dir_in,
  input  logic          mult_sel,
  input  logic          ref_clk,
  input  logic [DW-1:0] des_word,
  input  logic          des_vld,
  output logic          dir_out,
  output logic          par_oe,
  output logic [DW-1:0] par_dout,
  output logic [1:0]    range_code,
  output logic          ser_en,
  output logic          des_en,
  output logic          pd_rst,
  output logic          refs_en,
  output logic          pll_en,
  output logic          serial_io_en,
  output logic          ref_mode,
  output logic          frame_ovr,
  output logic          ready
);
  localparam int IW = $clog2(LOSS_TIMEOUT + 1);
  localparam int LW = $clog2(LOCK_WAIT + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(LOSS_TIMEOUT);
  localparam logic [LW-1:0] LOCK_MAX = LW'(LOCK_WAIT);

  logic          pd;
  logic [2:0]    sync_q;
  logic [1:0]    fill_q;
  logic          ref_edge;
  logic          clk_lost;
  logic          locked;
  logic          mode_q;
  logic [IW-1:0] idle_q;
  logic [LW-1:0] lock_q;
  logic [DW-1:0] dout_q;

  assign pd         = ~rng_a & ~rng_b;
  assign pd_rst     = pd;
  assign refs_en    = ~pd;
  assign range_code = pd ? 2'b00 : {rng_b, rng_a};
  assign dir_out    = ~dir_in;
  assign ser_en     = ~pd & dir_in;
  assign des_en     = ~pd & ~dir_in;
  assign par_oe     = des_en;
  assign frame_ovr  = ~pd & ~mult_sel;

  assign ref_edge   = (fill_q == 2'd3) & (sync_q[2] ^ sync_q[1]);
  assign clk_lost   = (idle_q == IDLE_MAX);
  assign locked     = (lock_q == LOCK_MAX);

  assign pll_en       = ~pd & mode_q & ~clk_lost;
  assign serial_io_en = ~pd & (~mode_q | ~clk_lost);
  assign ready        = ~pd & (~mode_q | (pll_en & locked));
  assign ref_mode     = mode_q;
  assign par_dout     = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      fill_q <= '0;
      mode_q <= 1'b0;
      idle_q <= IDLE_MAX;
      lock_q <= '0;
      dout_q <= '0;
    end else if (pd) begin
      sync_q <= '0;
      fill_q <= '0;
      mode_q <= 1'b0;
      idle_q <= IDLE_MAX;
      lock_q <= '0;
      dout_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ref_clk};
      if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
      if (ref_edge) begin
        mode_q <= 1'b1;
        idle_q <= '0;
      end else if (!clk_lost) begin
        idle_q <= idle_q + 1'b1;
      end
      if (!pll_en)     lock_q <= '0;
      else if (!locked) lock_q <= lock_q + 1'b1;
      if (des_en && des_vld) dout_q <= des_word;
    end
  end

  // R1
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> (!pll_en && !serial_io_en && !par_oe && !ready && !refs_en));
  // R1
  pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!ref_mode && par_dout == '0));
  // R3
  dir_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_out != dir_in);
  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd && !(des_en && des_vld)) |=> $stable(par_dout));
  // R7
  sticky_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_mode && !pd) |=> ref_mode);
  // R8
  pll_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> ref_mode);
  // R9
  ready_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ref_mode) |-> pll_en);
endmodule

// File: tb/sim_serdes_mode_ctrl.sv
`timescale 1ns/1ps
module sim_serdes_mode_ctrl;
  localparam int DW = 12;
  localparam int LT = 20;
  localparam int LK = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic rng_a = 1, rng_b = 1, dir_in = 0, mult_sel = 1, ref_clk = 0, des_vld = 0;
  logic [DW-1:0] des_word = '0;
  logic dir_out, par_oe, ser_en, des_en, pd_rst, refs_en, pll_en, serial_io_en;
  logic ref_mode, frame_ovr, ready;
  logic [DW-1:0] par_dout;
  logic [1:0] range_code;

  int tests = 0, fails = 0;
  int tog_per = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serdes_mode_ctrl #(.DW(DW), .LOSS_TIMEOUT(LT), .LOCK_WAIT(LK)) u0 (
    .clk(clk), .rst_n(rst_n), .rng_a(rng_a), .rng_b(rng_b), .dir_in(dir_in),
    .mult_sel(mult_sel), .ref_clk(ref_clk), .des_word(des_word), .des_vld(des_vld),
    .dir_out(dir_out), .par_oe(par_oe), .par_dout(par_dout), .range_code(range_code),
    .ser_en(ser_en), .des_en(des_en), .pd_rst(pd_rst), .refs_en(refs_en),
    .pll_en(pll_en), .serial_io_en(serial_io_en), .ref_mode(ref_mode),
    .frame_ovr(frame_ovr), .ready(ready));

  bit refq[$];
  bit m_mode = 0;
  int m_idle = LT;
  int m_lock = 0;
  logic [DW-1:0] m_dout = '0;

  always @(posedge clk) begin
    if (!rst_n || (!rng_a && !rng_b)) begin
      refq.delete(); m_mode = 0; m_idle = LT; m_lock = 0; m_dout = '0;
    end else begin
      bit edge_seen, pll_now;
      edge_seen = refq.size() >= 3 && refq[refq.size()-2] != refq[refq.size()-3];
      pll_now = m_mode && m_idle != LT;
      if (edge_seen) begin m_mode = 1; m_idle = 0; end
      else if (m_idle < LT) m_idle++;
      if (!pll_now) m_lock = 0; else if (m_lock < LK) m_lock++;
      if (!dir_in && des_vld) m_dout = des_word;
      refq.push_back(ref_clk);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit pd, lost, e_pll;
      pd = !rng_a && !rng_b;
      lost = (m_idle == LT);
      e_pll = !pd && m_mode && !lost;
      chk("R1", "pd_rst", pd_rst, pd);
      chk("R1", "refs_en", refs_en, !pd);
      chk("R2", "range_code", range_code, pd ? 0 : {rng_b, rng_a});
      chk("R3", "dir_out", dir_out, !dir_in);
      chk("R3", "ser_en", ser_en, !pd && dir_in);
      chk("R3", "des_en", des_en, !pd && !dir_in);
      chk("R4", "par_oe", par_oe, !pd && !dir_in);
      chk("R5", "par_dout", par_dout, m_dout);
      chk("R6", "frame_ovr", frame_ovr, !pd && !mult_sel);
      chk("R7", "ref_mode", ref_mode, m_mode);
      chk("R8", "pll_en", pll_en, e_pll);
      chk("R8", "serial_io_en", serial_io_en, !pd && (!m_mode || !lost));
      chk("R9", "ready", ready, !pd && (!m_mode || (e_pll && m_lock == LK)));
    end
  end

  int cyc = 0;
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cyc++;
      if (tog_per != 0 && (cyc % tog_per) == 0) ref_clk = ~ref_clk;
      des_word = DW'($urandom);
      des_vld = $urandom_range(0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #25;
    chk("R1", "reset par_dout", par_dout, 0);
    chk("R7", "reset ref_mode", ref_mode, 0);
    chk("R10", "reset pll_en", pll_en, 0);
    @(negedge clk); #1 rst_n = 1;
    run(10);                       // R10 external bit clock mode
    chk("R10", "ext ready", ready, 1);
    run(20);                       // R5 loads in deserializer direction
    tog_per = 4; run(60);          // R7 R9 reference appears, lock wait
    dir_in = 1; run(15);           // R5 hold across turn-around, R4
    tog_per = 0; run(35);          // R8 loss of reference
    chk("R8", "lost refs_en", refs_en, 1);
    tog_per = 3; run(30);          // R8 recovery
    mult_sel = 0; rng_a = 1; rng_b = 0; run(6);   // R6 R2
    rng_a = 0; rng_b = 1; dir_in = 0; run(6);
    ref_clk = 1; tog_per = 0;
    rng_a = 0; rng_b = 0; run(6);  // R1 power-down
    rng_a = 1; rng_b = 1; run(15); // R7 static high is no edge
    chk("R7", "static high ref_mode", ref_mode, 0);
    tog_per = 5; run(50);          // R10 -> R9 relock after power-up
    mult_sel = 1; run(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule